// File: doc/BRIEF.md
# Flag-Synchronized Receive Hold Gate

This block sits between a serial receive channel and a receive FIFO. Serial bits arrive one at a time on a data input, each qualified by a bit-valid strobe. After reset the block holds the receive path closed. No byte reaches the FIFO, and the asynchronous output stage is told to hold its line at the mark (logic 1) idle level. The path stays closed until the exact eight-bit flag 01111110 has arrived on the serial input.

When the flag is found, the block raises a synchronized status flag and opens the path. From the next valid bit onward it packs bits into bytes. It emits a single-cycle write strobe with each completed byte. The status flag stays high until the next reset. Later copies of the flag are treated as ordinary data and do not move the byte boundaries.

Top module: `rx_flag_gate`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), synced is 0, byte_wr is 0 and mark_idle is 1.
- R2: byte_wr never pulses while synced is 0.
- R3: mark_idle is 1 exactly while synced is 0.
- R4: synced goes to 1 in the cycle after the valid strobe that completes the flag 01111110. The first flag bit received is the leftmost bit of the pattern, a 0.
- R5: Only bits presented with bit_vld high take part in flag search and byte assembly. bit_in is ignored in cycles where bit_vld is low.
- R6: The flag must be made of eight valid bits received since reset. The seven bits 1111110 alone, right after reset, do not cause synchronization.
- R7: The first data bit is the valid bit right after the flag. byte_wr pulses for one cycle, in the cycle after every eighth valid data bit. byte_data then holds those eight bits, with the first one received in bit 7.
- R8: Once synced is 1, it stays 1 until reset. A flag pattern received after that is delivered as data, and byte boundaries stay where they were.
- R9: A reset in the middle of a stream returns the block to hold and drops any partly assembled byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bit_in | input | 1 | Serial receive data bit |
| bit_vld | input | 1 | High for one cycle when bit_in carries a new bit |
| synced | output | 1 | High once the flag has been received |
| byte_wr | output | 1 | One-cycle write strobe toward the receive FIFO |
| byte_data | output | 8 | Assembled byte, valid while byte_wr is high |
| mark_idle | output | 1 | Tells the asynchronous output stage to hold the mark level |

## Verification
The flag search is tried with three kinds of input:
- The bare seven-bit tail of the flag straight after reset. This separates a true eight-bit match from a match padded by reset-cleared history.
- The flag with invalid cycles placed between its bits, carrying the wrong level on bit_in. This shows whether unqualified bits leak into the search.
- Random noise ahead of the flag.

After synchronization, random data with a random valid duty cycle checks byte packing and bit order. A flag pattern placed at a misaligned position in the data shows whether framing stays fixed. A reset in mid-byte shows that partial bytes are dropped and the hold state returns.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
   localparam int unsigned RXG_WORD_W = 8;
   localparam logic [7:0]  RXG_FLAG   = 8'b0111_1110;

   function automatic int unsigned rxg_cnt_w(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rxg_flag_det.sv
module rxg_flag_det #(
   parameter int unsigned       W       = 8,
   parameter logic [W-1:0]      PATTERN = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic bit_vld,
   output logic hit
);
   import rxg_pkg::*;
   localparam int unsigned FW = rxg_cnt_w(W);
   localparam logic [FW-1:0] FULL = FW'(W - 1);

   logic [W-2:0]  hist_q;
   logic [FW-1:0] fill_q;
   logic          full;

   assign full = (fill_q == FULL);
   assign hit  = bit_vld && full && ({hist_q, bit_in} == PATTERN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (bit_vld) begin
         hist_q <= {hist_q[W-3:0], bit_in};
         if (!full) fill_q <= fill_q + 1'b1;
      end
   end
endmodule

// File: rtl/rxg_deser.sv
module rxg_deser #(
   parameter int unsigned W         = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         bit_in,
   input  logic         bit_vld,
   output logic         wr,
   output logic [W-1:0] data
);
   import rxg_pkg::*;
   localparam int unsigned CW = rxg_cnt_w(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  acc_q;
   logic [W-1:0]  acc_nx;
   logic [CW-1:0] cnt_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign acc_nx = {acc_q[W-2:0], bit_in};
      end else begin : g_lsb
         assign acc_nx = {bit_in, acc_q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         cnt_q <= '0;
         wr    <= 1'b0;
         data  <= '0;
      end else begin
         wr <= 1'b0;
         if (!en) begin
            cnt_q <= '0;
         end else if (bit_vld) begin
            acc_q <= acc_nx;
            if (cnt_q == LAST) begin
               cnt_q <= '0;
               wr    <= 1'b1;
               data  <= acc_nx;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rx_flag_gate.sv
module rx_flag_gate #(
   parameter int unsigned          WORD_W    = rxg_pkg::RXG_WORD_W,
   parameter logic [WORD_W-1:0]    FLAG      = rxg_pkg::RXG_FLAG,
   parameter bit                   MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              bit_vld,
   output logic              synced,
   output logic              byte_wr,
   output logic [WORD_W-1:0] byte_data,
   output logic              mark_idle
);
   generate
      if (WORD_W < 3) begin : g_bad_width
         $error("rx_flag_gate: WORD_W must be at least 3");
      end
   endgenerate

   logic flag_hit;
   logic synced_q;

   rxg_flag_det #(.W(WORD_W), .PATTERN(FLAG)) i_det (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld), .hit(flag_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        synced_q <= 1'b0;
      else if (flag_hit) synced_q <= 1'b1;
   end

   rxg_deser #(.W(WORD_W), .MSB_FIRST(MSB_FIRST)) i_deser (
      .clk(clk), .rst_n(rst_n), .en(synced_q), .bit_in(bit_in), .bit_vld(bit_vld),
      .wr(byte_wr), .data(byte_data)
   );

   assign synced    = synced_q;
   assign mark_idle = ~synced_q;
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_vld,
   input logic synced,
   input logic byte_wr,
   input logic mark_idle
);
   a_r2_no_write_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !synced |-> !byte_wr);
   a_r3_mark_while_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !synced |-> mark_idle);
   a_r3_line_free_when_synced: assert property (@(posedge clk) disable iff (!rst_n)
      synced |-> !mark_idle);
   a_r8_sync_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      synced |=> synced);
   a_r4_sync_on_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> $past(bit_vld));
   a_r7_write_on_valid_bit: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr |-> $past(bit_vld));
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_wr |=> !byte_wr);
endmodule

bind rx_flag_gate rxg_chk i_rxg_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld),
   .synced(synced), .byte_wr(byte_wr), .mark_idle(mark_idle)
);

// File: tb/test_rx_flag_gate.sv
module test_rx_flag_gate;
   localparam logic [7:0] FLAG = 8'h7E;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_in = 1'b0;
   logic       bit_vld = 1'b0;
   logic       synced, byte_wr, mark_idle;
   logic [7:0] byte_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0] m_hist;
   int         m_fill;
   logic       m_sync;
   logic [7:0] m_acc;
   int         m_cnt;
   logic       e_wr;
   logic [7:0] e_byte;

   always #2.5 clk = ~clk;

   rx_flag_gate i_rx_flag_gate (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .synced(synced), .byte_wr(byte_wr), .byte_data(byte_data), .mark_idle(mark_idle)
   );

   function automatic logic [7:0] shl(input logic [7:0] v, input logic b);
      return {v[6:0], b};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_hist = '0; m_fill = 0; m_sync = 1'b0; m_acc = '0; m_cnt = 0;
      e_wr = 1'b0; e_byte = '0;
   endtask

   task automatic do_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0; bit_vld = 1'b0;
      @(posedge clk); @(posedge clk);
      #1;
      model_reset();
      chk({tag, " synced"}, 32'(synced), 32'd0);
      chk({tag, " byte_wr"}, 32'(byte_wr), 32'd0);
      chk({tag, " mark_idle"}, 32'(mark_idle), 32'd1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic b, input logic v, input string tag);
      logic was_sync;
      @(negedge clk);
      bit_in = b; bit_vld = v;
      @(posedge clk);
      #1;
      was_sync = m_sync;
      e_wr = 1'b0;
      if (v) begin
         if (was_sync) begin
            m_acc = shl(m_acc, b);
            m_cnt++;
            if (m_cnt == 8) begin
               e_wr = 1'b1; e_byte = m_acc; m_cnt = 0;
            end
         end
         m_hist = shl(m_hist, b);
         if (m_fill < 8) m_fill++;
         if (m_fill == 8 && m_hist == FLAG) m_sync = 1'b1;
      end
      chk({tag, " synced"}, 32'(synced), 32'(m_sync));
      chk({tag, " mark_idle"}, 32'(mark_idle), 32'(!m_sync));
      chk({tag, " byte_wr"}, 32'(byte_wr), 32'(e_wr));
      if (e_wr) chk({tag, " byte_data"}, 32'(byte_data), 32'(e_byte));
      @(negedge clk);
      bit_vld = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v, input string tag);
      for (int i = 7; i >= 0; i--) send(v[i], 1'b1, tag);
   endtask

   initial begin
      #(5ns * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      do_reset("R1");

      // R6: tail of the flag only, right after reset
      for (int i = 6; i >= 0; i--) send(FLAG[i], 1'b1, "R6");
      chk("R6 no early sync", 32'(synced), 32'd0);
      send(1'b1, 1'b1, "R6");

      // R5: flag with invalid cycles carrying the wrong level
      do_reset("R1");
      for (int i = 7; i >= 0; i--) begin
         send(!FLAG[i], 1'b0, "R5");
         send(FLAG[i], 1'b1, "R4");
      end
      chk("R4 synced after flag", 32'(synced), 32'd1);

      // R7: first byte directly after the flag
      send_byte(8'hA5, "R7");
      send_byte(8'h3C, "R7");

      // R8: misaligned flag inside the data stream
      for (int i = 0; i < 3; i++) send(1'b0, 1'b1, "R8");
      send_byte(FLAG, "R8");
      for (int i = 0; i < 5; i++) send(1'b1, 1'b1, "R8");
      chk("R8 still synced", 32'(synced), 32'd1);

      // R7: random data with random valid duty
      for (int i = 0; i < 400; i++)
         send(1'($urandom), ($urandom % 10) < 7, "R7");

      // R9: reset in the middle of a byte, R2 noise in hold
      for (int i = 0; i < 3; i++) send(1'b1, 1'b1, "R9");
      do_reset("R9");
      for (int i = 0; i < 60; i++) send(1'($urandom), 1'($urandom), "R2");

      // random noise, then flag, then data
      do_reset("R1");
      for (int i = 0; i < 40; i++) send(($urandom % 4) != 0, 1'b1, "R3");
      send_byte(FLAG, "R4");
      for (int i = 0; i < 200; i++) send(1'($urandom), ($urandom % 3) != 0, "R7");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule